// File: doc/BRIEF.md
# Sector Protection Command Sequencer

This block runs, from the host side, the bus sequence that locks one sector group of a parallel NOR-style flash array. The caller supplies a 9-bit group number and a start strobe. The sequencer raises a request for the elevated voltage on the flash reset line and waits for the supply to acknowledge it. It then writes the arm command, writes the lock command to the group, and waits for the lock to settle. After that it writes the check command and reads the status back. It repeats the lock-and-check loop until status bit 0 reports the group as locked or a retry budget runs out. Last, it drops the voltage request and waits for the reset line to return to its normal level before it signals the outcome.

The state machine has ten named states. IDLE waits for a start. HV_WAIT holds the voltage request until the acknowledge arrives. SETUP is the arm write. PROTECT is the lock write. SETTLE is the lock wait. VERIFY is the check write. READ is the status read. RELEASE waits for the acknowledge to fall. DONE is the success pulse and ABORT is the failure pulse. The transitions are:
- IDLE→HV_WAIT on start.
- HV_WAIT→SETUP on acknowledge.
- SETUP→PROTECT and PROTECT→SETTLE unconditionally.
- SETTLE→VERIFY when the wait counter expires.
- VERIFY→READ unconditionally.
- READ→RELEASE (locked, or budget spent) or READ→PROTECT (retry) at the end of the read window.
- RELEASE→DONE or RELEASE→ABORT when the acknowledge falls.
- DONE/ABORT→IDLE.

Top module: `sect_prot_seq`

## Requirements
- R1: Out of reset, and in every idle cycle, all strobes, flags and the voltage request are low, and the address and write data are zero.
- R2: A start is accepted only in IDLE. The cycle after, busy_o and hv_req_o are high, and no bus write occurs until hv_ack_i has been sampled high.
- R3: The first bus cycle after the acknowledge is a one-cycle write of 0x60 to address 0.
- R4: The next cycle is a one-cycle lock write of 0x60. Its address carries the latched group in bits 20..12, has bits 6, 1 and 0 at 0, 1 and 0, and has every other bit at 0. The address value is therefore group×4096 + 2.
- R5: After each lock write, the bus stays idle for exactly (CLK_HZ/1000)×SETTLE_US/1000 cycles (at least one). That is 50 cycles at 200 kHz and 250 µs.
- R6: The check write of 0x40 to the same address follows the wait. Then bus_oe_o is held high for RD_CYC cycles with that address. Only bit 0 of bus_rdata_i, sampled in the last read cycle, is used, and bits 15..1 have no effect.
- R7: If bit 0 reads 0 and fewer than MAX_TRIES lock writes have been issued, another lock write follows in the next cycle, followed by the wait and the check again.
- R8: If bit 0 reads 1, hv_req_o drops. Once hv_ack_i is sampled low, done_o is high for one cycle, and busy_o falls in the cycle after.
- R9: If bit 0 reads 0 after MAX_TRIES lock writes, the release happens as in R8, but err_o pulses for one cycle in place of done_o.
- R10: busy_o stays high from the cycle after acceptance through the done or error cycle. start_i and group_i are ignored while busy.
- R11: bus_we_o and bus_oe_o are never high together. Write data is zero outside write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in IDLE |
| group_i | input | 9 | Sector group number to lock |
| hv_req_o | output | 1 | Request for elevated voltage on the flash reset line |
| hv_ack_i | input | 1 | Elevated voltage present on the flash reset line |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: group locked |
| err_o | output | 1 | One-cycle pulse: retry budget exhausted |
| bus_addr_o | output | 21 | Flash address |
| bus_wdata_o | output | 16 | Flash write data |
| bus_rdata_i | input | 16 | Flash read data |
| bus_we_o | output | 1 | Write strobe, one cycle per command |
| bus_oe_o | output | 1 | Output enable for the status read |

## Verification
The properties assume that hv_ack_i rises only while hv_req_o is high and stays high until hv_req_o falls. They also assume that hv_ack_i then falls and stays low until the next request. The bench's supply model meets this by design: it raises the acknowledge a chosen number of cycles after it sees the request, and it drops the acknowledge a chosen number of cycles after the request is withdrawn. The flash model in the bench counts the lock writes it observes and keeps read data stable between them. Its high bits are always nonzero, so only bit 0 can steer the retry decision.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HV_WAIT,
        ST_SETUP,
        ST_PROTECT,
        ST_SETTLE,
        ST_VERIFY,
        ST_READ,
        ST_RELEASE,
        ST_DONE,
        ST_ABORT
    } spp_state_e;

    // Command byte for the arm write and the lock write
    localparam logic [7:0] CMD_ARM   = 8'h60;
    // Command byte for the check write
    localparam logic [7:0] CMD_CHECK = 8'h40;
    // Address bits 6..0 for lock and check writes: bit6=0, bit1=1, bit0=0
    localparam logic [6:0] SIG_LOW   = 7'b000_0010;

endpackage

// File: rtl/spp_cycle_timer.sv
module spp_cycle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          run_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spp_try_counter.sv
module spp_try_counter #(
    parameter int MAX_TRIES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_max_o
);

    localparam int NW = $clog2(MAX_TRIES + 1);

    logic [NW-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (clr_i) begin
            tries_q <= '0;
        end else if (inc_i && (tries_q < NW'(MAX_TRIES))) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign at_max_o = (tries_q >= NW'(MAX_TRIES));

endmodule

// File: rtl/spp_bus_fmt.sv
module spp_bus_fmt
    import spp_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int DATA_W  = 16,
    parameter int GRP_LSB = 12
) (
    input  spp_state_e                  state_i,
    input  logic [ADDR_W-GRP_LSB-1:0]   grp_i,
    output logic [ADDR_W-1:0]           addr_o,
    output logic [DATA_W-1:0]           wdata_o,
    output logic                        we_o,
    output logic                        oe_o
);

    localparam int GRP_W = ADDR_W - GRP_LSB;

    logic [ADDR_W-1:0] target_addr;

    // Group field on top, signature in bits 6..0, all other low bits zero
    assign target_addr = {grp_i[GRP_W-1:0], GRP_LSB'(SIG_LOW)};

    always_comb begin
        addr_o  = '0;
        wdata_o = '0;
        we_o    = 1'b0;
        oe_o    = 1'b0;
        unique case (state_i)
            ST_SETUP: begin
                we_o    = 1'b1;
                wdata_o = DATA_W'(CMD_ARM);
            end
            ST_PROTECT: begin
                we_o    = 1'b1;
                addr_o  = target_addr;
                wdata_o = DATA_W'(CMD_ARM);
            end
            ST_VERIFY: begin
                we_o    = 1'b1;
                addr_o  = target_addr;
                wdata_o = DATA_W'(CMD_CHECK);
            end
            ST_READ: begin
                oe_o    = 1'b1;
                addr_o  = target_addr;
            end
            ST_IDLE, ST_HV_WAIT, ST_SETTLE, ST_RELEASE, ST_DONE, ST_ABORT: begin
                we_o    = 1'b0;
            end
            default: begin
                we_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sect_prot_seq.sv
module sect_prot_seq
    import spp_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int GRP_LSB   = 12,
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_US = 250,
    parameter int RD_CYC    = 2,
    parameter int MAX_TRIES = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-GRP_LSB-1:0] group_i,
    output logic                      hv_req_o,
    input  logic                      hv_ack_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      err_o,
    output logic [ADDR_W-1:0]         bus_addr_o,
    output logic [DATA_W-1:0]         bus_wdata_o,
    input  logic [DATA_W-1:0]         bus_rdata_i,
    output logic                      bus_we_o,
    output logic                      bus_oe_o
);

    localparam int GRP_W     = ADDR_W - GRP_LSB;
    localparam int WAIT_RAW  = (CLK_HZ / 1000) * SETTLE_US / 1000;
    localparam int WAIT_CYC  = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int RD_LEN    = (RD_CYC < 1) ? 1 : RD_CYC;
    localparam int TMAX      = (WAIT_CYC > RD_LEN) ? WAIT_CYC : RD_LEN;
    localparam int CW        = $clog2(TMAX + 1);

    spp_state_e        state_q, state_d;
    logic [GRP_W-1:0]  grp_q;
    logic              ok_q;
    logic              accept;
    logic              tmr_load, tmr_run, tmr_zero;
    logic [CW-1:0]     tmr_val;
    logic              at_max;
    logic              locked_bit;
    logic              unused_rd_hi;

    assign accept       = (state_q == ST_IDLE) && start_i;
    assign locked_bit   = bus_rdata_i[0];
    assign unused_rd_hi = ^bus_rdata_i[DATA_W-1:1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Latched operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            if (accept) begin
                grp_q <= group_i;
                ok_q  <= 1'b0;
            end else if ((state_q == ST_READ) && tmr_zero) begin
                ok_q  <= locked_bit;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)   state_d = ST_HV_WAIT;
            ST_HV_WAIT: if (hv_ack_i)  state_d = ST_SETUP;
            ST_SETUP:                  state_d = ST_PROTECT;
            ST_PROTECT:                state_d = ST_SETTLE;
            ST_SETTLE:  if (tmr_zero)  state_d = ST_VERIFY;
            ST_VERIFY:                 state_d = ST_READ;
            ST_READ: begin
                if (tmr_zero) begin
                    if (locked_bit || at_max) state_d = ST_RELEASE;
                    else                      state_d = ST_PROTECT;
                end
            end
            ST_RELEASE: if (!hv_ack_i) state_d = ok_q ? ST_DONE : ST_ABORT;
            ST_DONE:                   state_d = ST_IDLE;
            ST_ABORT:                  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Control outputs
    always_comb begin
        hv_req_o = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        err_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy_o   = 1'b0;
            ST_HV_WAIT,
            ST_SETUP,
            ST_PROTECT,
            ST_SETTLE,
            ST_VERIFY,
            ST_READ:    hv_req_o = 1'b1;
            ST_RELEASE: hv_req_o = 1'b0;
            ST_DONE:    done_o   = 1'b1;
            ST_ABORT:   err_o    = 1'b1;
            default:    busy_o   = 1'b0;
        endcase
    end

    // Wait timer shared by the settle window and the read window
    assign tmr_load = (state_q == ST_PROTECT) || (state_q == ST_VERIFY);
    assign tmr_run  = (state_q == ST_SETTLE) || (state_q == ST_READ);
    assign tmr_val  = (state_q == ST_PROTECT) ? CW'(WAIT_CYC - 1) : CW'(RD_LEN - 1);

    spp_cycle_timer #(
        .CW(CW)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .zero_o     (tmr_zero)
    );

    spp_try_counter #(
        .MAX_TRIES(MAX_TRIES)
    ) tries_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (accept),
        .inc_i    (state_q == ST_PROTECT),
        .at_max_o (at_max)
    );

    spp_bus_fmt #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .GRP_LSB (GRP_LSB)
    ) bus_i (
        .state_i (state_q),
        .grp_i   (grp_q),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o),
        .we_o    (bus_we_o),
        .oe_o    (bus_oe_o)
    );

endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int GRP_LSB   = 12,
    parameter int CLK_HZ    = 50_000_000,
    parameter int SETTLE_US = 250,
    parameter int MAX_TRIES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_req_o,
    input logic              hv_ack_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_we_o,
    input logic              bus_oe_o
);

    localparam int WAIT_RAW = (CLK_HZ / 1000) * SETTLE_US / 1000;
    localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

    logic              lock_wr, check_wr;
    int unsigned       gap_q;
    int unsigned       tries_q;
    logic [ADDR_W-1:0] lock_addr_q;

    assign lock_wr  = bus_we_o && (bus_wdata_o == DATA_W'(8'h60)) && (bus_addr_o != '0);
    assign check_wr = bus_we_o && (bus_wdata_o == DATA_W'(8'h40));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= 0;
            tries_q     <= 0;
            lock_addr_q <= '0;
        end else begin
            if (lock_wr) begin
                gap_q       <= 0;
                lock_addr_q <= bus_addr_o;
            end else if (!bus_we_o && !bus_oe_o) begin
                gap_q <= gap_q + 1;
            end
            if (!busy_o)       tries_q <= 0;
            else if (lock_wr)  tries_q <= tries_q + 1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_we_o && !bus_oe_o && !hv_req_o && !done_o && !err_o));

    assert_write_needs_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_o |-> (hv_req_o && hv_ack_i));

    assert_lock_signature_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |-> (bus_addr_o[GRP_LSB-1:0] == GRP_LSB'(2)));

    assert_settle_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        check_wr |-> (gap_q == WAIT_CYC));

    assert_check_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        check_wr |-> (bus_addr_o == lock_addr_q));

    assert_read_after_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(check_wr));

    assert_try_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q <= MAX_TRIES);

    assert_end_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> (!hv_req_o && !hv_ack_i && !(done_o && err_o)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!err_o && !busy_o));

    assert_err_after_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (tries_q == MAX_TRIES));

    assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o || err_o));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_o && bus_oe_o));

endmodule

bind sect_prot_seq spp_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .GRP_LSB   (GRP_LSB),
    .CLK_HZ    (CLK_HZ),
    .SETTLE_US (SETTLE_US),
    .MAX_TRIES (MAX_TRIES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv_req_o    (hv_req_o),
    .hv_ack_i    (hv_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_we_o    (bus_we_o),
    .bus_oe_o    (bus_oe_o)
);

// File: tb/sect_prot_seq_tb_top.sv
module sect_prot_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 200_000;
    localparam int TB_SET_US  = 250;
    localparam int TB_RD      = 2;
    localparam int TB_MAX     = 3;
    localparam int EXP_WAIT   = (TB_CLK_HZ / 1000) * TB_SET_US / 1000; // R5: 50 cycles
    localparam int WDOG_CYC   = 150_000;

    typedef struct packed {
        logic        we;
        logic        oe;
        logic        hv;
        logic        busy;
        logic        done;
        logic        err;
        logic [20:0] addr;
        logic [15:0] wd;
    } obs_t;

    logic        clk;
    logic        rst_n;
    logic        start_i;
    logic [8:0]  group_i;
    logic        hv_req_o;
    logic        hv_ack_i;
    logic        busy_o;
    logic        done_o;
    logic        err_o;
    logic [20:0] bus_addr_o;
    logic [15:0] bus_wdata_o;
    logic [15:0] bus_rdata_i;
    logic        bus_we_o;
    logic        bus_oe_o;

    int checks   = 0;
    int failures = 0;
    obs_t  exp_q[$];
    string tag_q[$];

    int env_a, env_d, env_fail;
    int ack_cnt, rel_cnt, pw_cnt;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    sect_prot_seq #(
        .CLK_HZ    (TB_CLK_HZ),
        .SETTLE_US (TB_SET_US),
        .RD_CYC    (TB_RD),
        .MAX_TRIES (TB_MAX)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .group_i     (group_i),
        .hv_req_o    (hv_req_o),
        .hv_ack_i    (hv_ack_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_rdata_i (bus_rdata_i),
        .bus_we_o    (bus_we_o),
        .bus_oe_o    (bus_oe_o)
    );

    function automatic obs_t mk(input logic we, input logic oe, input logic hv,
                                input logic busy, input logic done, input logic err,
                                input logic [20:0] addr, input logic [15:0] wd);
        obs_t o;
        o.we = we; o.oe = oe; o.hv = hv; o.busy = busy;
        o.done = done; o.err = err; o.addr = addr; o.wd = wd;
        return o;
    endfunction

    function automatic obs_t sample();
        return mk(bus_we_o, bus_oe_o, hv_req_o, busy_o, done_o, err_o, bus_addr_o, bus_wdata_o);
    endfunction

    task automatic push(input obs_t o, input string t, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(o);
            tag_q.push_back(t);
        end
    endtask

    task automatic compare(input obs_t e, input string t);
        obs_t a;
        a = sample();
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s t=%0t actual we=%0b oe=%0b hv=%0b busy=%0b done=%0b err=%0b addr=%h wd=%h expected we=%0b oe=%0b hv=%0b busy=%0b done=%0b err=%0b addr=%h wd=%h",
                     t, $time, a.we, a.oe, a.hv, a.busy, a.done, a.err, a.addr, a.wd,
                     e.we, e.oe, e.hv, e.busy, e.done, e.err, e.addr, e.wd);
        end
    endtask

    // Supply and flash models, reacting to the observed outputs
    task automatic env_step();
        if (hv_req_o && !hv_ack_i) begin
            ack_cnt++;
            if (ack_cnt == env_a) hv_ack_i = 1'b1;
        end
        if (!hv_req_o && hv_ack_i) begin
            rel_cnt++;
            if (rel_cnt == env_d) hv_ack_i = 1'b0;
        end
        if (bus_we_o && bus_wdata_o == 16'h0060 && bus_addr_o != 21'd0) pw_cnt++;
        // R6: high bits always nonzero, only bit 0 carries the status
        bus_rdata_i = (pw_cnt > env_fail) ? 16'hA5A5 : 16'hA5A4;
    endtask

    task automatic run_case(input logic [8:0] grp, input int a, input int fails,
                            input int d, input bit disturb);
        logic [20:0] ga;
        int attempts;
        bit ok;
        int idx;
        ga = {grp, 12'h002};
        ok = (fails < TB_MAX);
        attempts = ok ? fails + 1 : TB_MAX;
        exp_q.delete();
        tag_q.delete();
        push(mk(0,0,1,1,0,0,21'd0,16'h0000), disturb ? "R10" : "R2", a);
        push(mk(1,0,1,1,0,0,21'd0,16'h0060), "R3", 1);
        for (int i = 0; i < attempts; i++) begin
            push(mk(1,0,1,1,0,0,ga,16'h0060), (i == 0) ? "R4" : "R7", 1);
            push(mk(0,0,1,1,0,0,21'd0,16'h0000), "R5", EXP_WAIT);
            push(mk(1,0,1,1,0,0,ga,16'h0040), "R6", 1);
            push(mk(0,1,1,1,0,0,ga,16'h0000), "R6/R11", TB_RD);
        end
        push(mk(0,0,0,1,0,0,21'd0,16'h0000), ok ? "R8" : "R9", d);
        push(mk(0,0,0,1,ok,!ok,21'd0,16'h0000), ok ? "R8" : "R9", 1);
        push(mk(0,0,0,0,0,0,21'd0,16'h0000), "R10", 2);

        env_a = a; env_d = d; env_fail = fails;
        ack_cnt = 0; rel_cnt = 0; pw_cnt = 0;
        @(negedge clk);
        start_i = 1'b1;
        group_i = grp;
        env_step();
        idx = 0;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            if (idx == 0) start_i = 1'b0;
            compare(exp_q.pop_front(), tag_q.pop_front());
            env_step();
            if (disturb && idx == 3) begin
                start_i = 1'b1;        // R10: ignored while busy
                group_i = ~grp;
            end else if (disturb && idx == 4) begin
                start_i = 1'b0;
            end
            idx++;
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        start_i     = 1'b0;
        group_i     = 9'd0;
        hv_ack_i    = 1'b0;
        bus_rdata_i = 16'h0000;
        env_a = 1; env_d = 1; env_fail = 0;
        ack_cnt = 0; rel_cnt = 0; pw_cnt = 0;
        repeat (3) @(negedge clk);
        compare(mk(0,0,0,0,0,0,21'd0,16'h0000), "R1");
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            compare(mk(0,0,0,0,0,0,21'd0,16'h0000), "R1");
        end

        run_case(9'h1A5, 2, 0, 1, 1'b0);   // R8 locked on first check
        run_case(9'h000, 1, 2, 3, 1'b0);   // R7 locked on last allowed try
        run_case(9'h1FF, 4, 5, 2, 1'b0);   // R9 budget exhausted
        run_case(9'h100, 1, 3, 1, 1'b0);   // R9 exactly MAX failures
        run_case(9'h0B3, 3, 1, 1, 1'b1);   // R10 start and group change ignored

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule